// File: doc/BRIEF.md
# Performance Event Slot

One slot of a hardware performance monitor: a 64-bit event counter paired with a selector register. The selector picks one event class and a mask of events inside that class. On every clock the counter advances by the number of enabled events of the chosen class that are asserted on the event bus in that cycle.

Software reaches both registers through a small CSR-style port with an address bit, a write strobe, write data and combinational read data. Address 0 selects the selector and address 1 selects the counter. Selector writes are legalised on the way in: mask bits that the chosen class does not define are dropped. A class this slot cannot count clears the selector.

The event bus carries five classes of 20 lines each. Line `k` of class `c` is `ev_bus[c*20+k]` and corresponds to selector mask bit `k+5`.

Top module: `perf_event_slot`

## Requirements
- R1: After reset the selector (address 0) and the counter (address 1) both read 0.
- R2: The selector fields are: bit 0 is the no-event flag, bits 4:1 are the class code and bits 24:5 are the event mask. A legal write reads back with the same field values.
- R3: Only these mask bits are kept on a selector write: bits 24:5 for class 0, bits 10:5 for classes 1 and 2, bits 8:6 for class 3, and bits 6:5 for class 4. Every other mask bit reads back as 0.
- R4: A selector write with a class code from 5 to 15 leaves the selector reading 0, and the slot then counts nothing.
- R5: While the no-event flag is 1, or while the mask is 0, the counter holds its value whatever the event bus carries.
- R6: In each cycle the counter adds the number of asserted event lines whose mask bit is set, taken only from the selected class. Line `ev_bus[c*20+k]` maps to mask bit `k+5` of class `c`, and lines of the other classes have no effect.
- R7: The counter is 64 bits wide and can be written and read in full at address 1. A counter write in the same cycle as counted events loads the written value, and the increment is lost.
- R8: Selector bits 63:25 read as 0 and ignore written ones.
- R9: The counter wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 1 | 0 selects the selector, 1 selects the counter |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for the addressed register (combinational) |
| ev_bus | input | 100 | Event lines, 20 per class, for classes 0 to 4 |

## Verification
The bench writes an all-ones mask under each class. A design with a wrong legal mask for any class reads back stray bits or counts the wrong number of events. The event patterns also assert lines in classes other than the selected one and on undefined lanes, so a design that picks the wrong slice, or does not mask it, miscounts. Further cases cover illegal class codes, a set no-event flag and dirty upper selector bits. A counter write that collides with a burst of events catches a design that adds to the written value. A count that steps past 2^64 - 1 catches a design that saturates instead of wrapping.

// File: rtl/perf_event_slot.sv
module perf_event_slot #(
  parameter int CNT_W    = 64,
  parameter int EV_W     = 20,
  parameter int NCLS     = 5,
  parameter int CLS_W    = 4,
  parameter int MASK_LSB = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_addr,
  input  logic                 csr_we,
  input  logic [CNT_W-1:0]     csr_wdata,
  output logic [CNT_W-1:0]     csr_rdata,
  input  logic [NCLS*EV_W-1:0] ev_bus
);
  localparam int SEL_W = MASK_LSB + EV_W;
  localparam int INC_W = $clog2(EV_W + 1);

  function automatic logic [EV_W-1:0] legal_mask(input logic [CLS_W-1:0] c);
    case (c)
      CLS_W'(0):            legal_mask = '1;
      CLS_W'(1), CLS_W'(2): legal_mask = EV_W'(6'h3f);
      CLS_W'(3):            legal_mask = EV_W'(4'he);
      CLS_W'(4):            legal_mask = EV_W'(2'h3);
      default:              legal_mask = '0;
    endcase
  endfunction

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;

  wire              sel_off  = sel_q[0];
  wire [CLS_W-1:0]  sel_cls  = sel_q[MASK_LSB-1:1];
  wire [EV_W-1:0]   sel_mask = sel_q[SEL_W-1:MASK_LSB];

  wire [CLS_W-1:0]  wr_cls   = csr_wdata[MASK_LSB-1:1];
  wire              wr_ok    = wr_cls < CLS_W'(NCLS);
  wire [SEL_W-1:0]  sel_d    = wr_ok ? {csr_wdata[SEL_W-1:MASK_LSB] & legal_mask(wr_cls),
                                        wr_cls, csr_wdata[0]} : '0;

  logic [EV_W-1:0]  slice;
  always_comb begin
    slice = '0;
    for (int c = 0; c < NCLS; c++)
      if (sel_cls == CLS_W'(c)) slice = ev_bus[c*EV_W +: EV_W];
  end

  wire [EV_W-1:0] hits = sel_off ? '0 : (slice & sel_mask);

  logic [INC_W-1:0] inc;
  always_comb begin
    inc = '0;
    for (int i = 0; i < EV_W; i++) inc = inc + INC_W'(hits[i]);
  end

  wire wr_sel = csr_we && !csr_addr;
  wire wr_cnt = csr_we &&  csr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_sel) sel_q <= sel_d;
      if (wr_cnt) cnt_q <= csr_wdata;
      else        cnt_q <= cnt_q + CNT_W'(inc);
    end
  end

  assign csr_rdata = csr_addr ? cnt_q : CNT_W'(sel_q);

  // R3
  mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask & ~legal_mask(sel_cls)) == '0);

  // R4
  class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cls < CLS_W'(NCLS));

  // R5
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_off && !wr_cnt) |=> cnt_q == $past(cnt_q));

  // R6
  inc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q - $past(cnt_q)) <= CNT_W'(EV_W));

  // R7
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(csr_wdata));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_addr |-> csr_rdata[CNT_W-1:SEL_W] == '0);
endmodule

// File: tb/perf_event_slot_test.sv
`timescale 1ns/1ps
module perf_event_slot_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        csr_addr = 0;
  logic        csr_we = 0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic [99:0] ev_bus = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  perf_event_slot uut (.clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
                       .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ev_bus(ev_bus));

  // {selector write data, event bus, expected selector, expected count}
  localparam logic [171:0] VEC [10] = '{
    {32'h01FF_FFE0, 100'hF_FFFF,                          32'h01FF_FFE0, 8'd20}, // R2 R6 class 0
    {32'h01FF_FFE2, 100'hFF_FFFF_FFFF,                    32'h0000_07E2, 8'd6},  // R3 R6 class 1
    {32'h01FF_FFE4, 100'h405 << 40,                       32'h0000_07E4, 8'd2},  // R3 R6 class 2
    {32'h01FF_FFE6, 100'hF_FFFF << 60,                    32'h0000_01C6, 8'd3},  // R3 class 3
    {32'h01FF_FFE8, 100'hF_FFFF << 80,                    32'h0000_0068, 8'd2},  // R3 class 4
    {32'h01FF_FFEA, {100{1'b1}},                          32'h0000_0000, 8'd0},  // R4 class 5
    {32'hFFFF_FFFE, {100{1'b1}},                          32'h0000_0000, 8'd0},  // R4 class 15
    {32'h01FF_FFE1, {100{1'b1}},                          32'h01FF_FFE1, 8'd0},  // R5 flag
    {32'hFE00_00A0, 100'h7,                               32'h0000_00A0, 8'd2},  // R8 upper bits
    {32'h0000_0000, {100{1'b1}},                          32'h0000_0000, 8'd0}   // R5 empty mask
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_we = 1; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(input logic a, output logic [63:0] v);
    csr_addr = a; #1; v = csr_rdata;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); check("R1 selector", v, 64'd0);
    rd(1, v); check("R1 counter", v, 64'd0);
    ev_bus = '1;
    @(negedge clk);
    ev_bus = '0;
    rd(1, v); check("R5 reset selector", v, 64'd0);

    for (int i = 0; i < 10; i++) begin
      wr(0, {32'd0, VEC[i][171:140]});
      wr(1, 64'd0);
      ev_bus = VEC[i][139:40];
      @(negedge clk);
      ev_bus = '0;
      rd(0, v); check($sformatf("R2/R3/R4/R8 vec%0d selector", i), v, {32'd0, VEC[i][39:8]});
      rd(1, v); check($sformatf("R5/R6 vec%0d count", i), v, {56'd0, VEC[i][7:0]});
    end

    wr(0, 64'h01FF_FFE0);
    wr(1, 64'h1234_5678_9ABC_DEF0);
    rd(1, v); check("R7 full readback", v, 64'h1234_5678_9ABC_DEF0);

    @(negedge clk);
    csr_addr = 1; csr_we = 1; csr_wdata = 64'd100; ev_bus = 100'hF_FFFF;
    @(negedge clk);
    csr_we = 0;
    rd(1, v); check("R7 write wins", v, 64'd100);
    @(negedge clk);
    ev_bus = '0;
    rd(1, v); check("R7 counting resumes", v, 64'd120);

    wr(1, 64'hFFFF_FFFF_FFFF_FFFE);
    ev_bus = 100'h7;
    @(negedge clk);
    ev_bus = '0;
    rd(1, v); check("R9 wrap", v, 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule